// File: doc/BRIEF.md
# Smart-Card Receive Queue with Parity Policy

This block sits behind a smart-card character receiver. Each received character arrives as one valid beat carrying a byte and a parity-error flag. The block keeps accepted characters in a small first-in first-out store whose depth the host sets from one to eight. The host drains the store through a valid/ready read port.

Parity errors are handled according to the selected protocol. Under T=0, a bad character is discarded and counted against a limit the host programs. Under T=1, a bad character is kept and flagged. Status outputs report full, empty, parity error and overrun. An active-low interrupt combines the conditions that need the host's attention.

A synchronous-card mode replaces bit 0 of the read data with the live card I/O level. The intake never pushes back: `in_ready` is held high. Characters that cannot be stored are dropped, and the drop is recorded as described in the requirements. On the read side, a character leaves the store only in a cycle where `out_valid` and `out_ready` are both high.

Top module: `card_rx_queue`

## Requirements
- R1: The store capacity is n = `cfg_depth` + 1 characters (`cfg_depth` from 0 to 7 gives n from 1 to 8). `st_full` is high exactly while the store holds n characters.
- R2: With `cfg_t1` = 0, a beat whose `in_perr` = 1 is never stored. The read side is unchanged by it.
- R3: With `cfg_t1` = 0, each parity-error beat advances an error count while the count is armed. The beat that brings the count to `cfg_err_lim` + 1 sets `st_perr` and disarms the count. Once disarmed, further errors never set `st_perr` again.
- R4: A one-cycle `cfg_err_load` pulse clears the error count and arms it again.
- R5: With `cfg_t1` = 1, a beat whose `in_perr` = 1 is stored like any other character, and `st_perr` is set.
- R6: A single read from a full store clears `st_full` on the next cycle.
- R7: `st_empty` is high and `out_valid` is low while no character is held. Characters leave in arrival order. `in_ready` is always 1.
- R8: When `cfg_sync` = 1, bit 0 of `out_data` follows `card_io`. Bits 7 to 1 still come from the head of the store.
- R9: A storable beat arriving while `st_full` is high is discarded and sets `st_overrun`. `st_overrun` stays set until a status read.
- R10: A `stat_rd` pulse clears `st_perr` and `st_overrun`. If a set event occurs in the same cycle, the set wins.
- R11: `irq_n` is low exactly when `st_full`, `st_perr` or `st_overrun` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received character is presented |
| in_ready | output | 1 | Always 1; the intake never stalls |
| in_data | input | 8 | Received byte |
| in_perr | input | 1 | Parity error seen on this character |
| out_valid | output | 1 | The store holds at least one character |
| out_ready | input | 1 | Host read strobe; pops when out_valid is high |
| out_data | output | 8 | Head character (bit 0 replaced in sync mode) |
| cfg_depth | input | 3 | Store depth minus one |
| cfg_t1 | input | 1 | 1 selects T=1 parity policy, 0 selects T=0 |
| cfg_err_lim | input | 3 | Error limit minus one |
| cfg_err_load | input | 1 | Pulse: clear and re-arm the error count |
| cfg_sync | input | 1 | Synchronous-card mode |
| card_io | input | 1 | Live level of the selected card I/O line |
| stat_rd | input | 1 | Pulse: the host has read the status |
| st_full | output | 1 | Store holds n characters |
| st_empty | output | 1 | Store holds no character |
| st_perr | output | 1 | Parity error flag |
| st_overrun | output | 1 | Character lost to a full store |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume the configuration inputs (`cfg_depth`, `cfg_t1`, `cfg_err_lim`) hold still while characters are in flight. In particular, the property on clearing full relies on the depth not changing between a read and the next cycle. The stimulus follows this rule: it changes configuration only while the store is empty and no beat is being presented. It also drives every pulse input for exactly one cycle, and it changes inputs only between clock edges.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic {
    PROTO_T0 = 1'b0,
    PROTO_T1 = 1'b1
  } proto_e;

  function automatic logic is_t0_drop(input logic valid, input logic perr, input proto_e proto);
    return valid && perr && (proto == PROTO_T0);
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DW        = 8,
  parameter int MAX_DEPTH = 8,
  localparam int PW       = $clog2(MAX_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [PW:0]   level
);
  localparam logic [PW-1:0] LAST = PW'(MAX_DEPTH - 1);

  logic [DW-1:0] slots [MAX_DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rdata = slots[rd_ptr];
endmodule

// File: rtl/rxq_errcnt.sv
module rxq_errcnt #(
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          err_evt,
  input  logic          load,
  input  logic [LW-1:0] lim,
  output logic          hit
);
  logic [LW-1:0] cnt;
  logic          armed;

  assign hit = err_evt && armed && !load && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (load) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (err_evt && armed) begin
      if (cnt == lim) armed <= 1'b0;
      else            cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_perr,
  input  logic set_ovr,
  input  logic clr,
  output logic perr,
  output logic ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      perr <= set_perr | (perr & ~clr);
      ovr  <= set_ovr  | (ovr  & ~clr);
    end
  end
endmodule

// File: rtl/card_rx_queue.sv
module card_rx_queue
  import rxq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MAX_DEPTH = 8,
  localparam int PW       = $clog2(MAX_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_perr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  input  logic [PW-1:0] cfg_depth,
  input  logic          cfg_t1,
  input  logic [PW-1:0] cfg_err_lim,
  input  logic          cfg_err_load,
  input  logic          cfg_sync,
  input  logic          card_io,
  input  logic          stat_rd,
  output logic          st_full,
  output logic          st_empty,
  output logic          st_perr,
  output logic          st_overrun,
  output logic          irq_n
);
  proto_e        proto;
  logic [PW:0]   level, depth_n;
  logic [DW-1:0] head;
  logic          drop_t0, want_store, push, pop, cnt_hit, perr_set, ovr_set;

  assign proto      = cfg_t1 ? PROTO_T1 : PROTO_T0;
  assign depth_n    = {1'b0, cfg_depth} + {{PW{1'b0}}, 1'b1};
  assign st_full    = (level >= depth_n);
  assign st_empty   = (level == '0);
  assign in_ready   = 1'b1;
  assign out_valid  = !st_empty;

  assign drop_t0    = is_t0_drop(in_valid, in_perr, proto);
  assign want_store = in_valid && !drop_t0;
  assign push       = want_store && !st_full;
  assign pop        = out_valid && out_ready;
  assign ovr_set    = want_store && st_full;
  assign perr_set   = (in_valid && in_perr && proto == PROTO_T1) || cnt_hit;

  rxq_store #(.DW(DW), .MAX_DEPTH(MAX_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(in_data),
    .pop(pop), .rdata(head), .level(level)
  );

  rxq_errcnt #(.LW(PW)) u_errcnt (
    .clk(clk), .rst_n(rst_n), .err_evt(drop_t0), .load(cfg_err_load),
    .lim(cfg_err_lim), .hit(cnt_hit)
  );

  rxq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_perr(perr_set), .set_ovr(ovr_set),
    .clr(stat_rd), .perr(st_perr), .ovr(st_overrun)
  );

  generate
    if (DW > 1) begin : g_wide
      assign out_data = cfg_sync ? {head[DW-1:1], card_io} : head;
    end else begin : g_narrow
      assign out_data = cfg_sync ? card_io : head;
    end
  endgenerate

  assign irq_n = !(st_full || st_perr || st_overrun);
endmodule

// File: rtl/card_rx_queue_chk.sv
module card_rx_queue_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_perr,
  input logic out_ready,
  input logic cfg_t1,
  input logic stat_rd,
  input logic st_full,
  input logic st_empty,
  input logic st_perr,
  input logic st_overrun,
  input logic irq_n
);
  // R2
  t0_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_t1 && in_valid && in_perr && st_empty) |=> st_empty);

  // R5
  t1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_t1 && in_valid && in_perr && st_empty) |=> (!st_empty && st_perr));

  // R6
  full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full && out_ready && !in_valid) |=> !st_full);

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full && in_valid && (cfg_t1 || !in_perr)) |=> st_overrun);

  // R10
  perr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(in_valid && in_perr)) |=> !st_perr);

  // R11
  irq_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_perr || st_overrun) |-> !irq_n);
endmodule

bind card_rx_queue card_rx_queue_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_perr(in_perr),
  .out_ready(out_ready), .cfg_t1(cfg_t1), .stat_rd(stat_rd),
  .st_full(st_full), .st_empty(st_empty), .st_perr(st_perr),
  .st_overrun(st_overrun), .irq_n(irq_n)
);

// File: tb/card_rx_queue_bench.sv
module card_rx_queue_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_perr = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic [2:0] cfg_depth = 3'd3, cfg_err_lim = 3'd0;
  logic       cfg_t1 = 1'b0, cfg_err_load = 1'b0, cfg_sync = 1'b0, card_io = 1'b0, stat_rd = 1'b0;
  logic       in_ready, out_valid, st_full, st_empty, st_perr, st_overrun, irq_n;
  logic [7:0] out_data;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // model state, built from the requirements
  logic [7:0] exp_q [$];
  int  m_cnt = 0;
  bit  m_armed = 1, m_perr = 0, m_ovr = 0;

  always #4 clk = ~clk;

  card_rx_queue u_card_rx_queue (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_perr(in_perr), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .cfg_depth(cfg_depth),
    .cfg_t1(cfg_t1), .cfg_err_lim(cfg_err_lim), .cfg_err_load(cfg_err_load),
    .cfg_sync(cfg_sync), .card_io(card_io), .stat_rd(stat_rd),
    .st_full(st_full), .st_empty(st_empty), .st_perr(st_perr),
    .st_overrun(st_overrun), .irq_n(irq_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_status(string req);
    int  depth = int'(cfg_depth) + 1;
    bit  full  = (exp_q.size() >= depth);
    chk({req, " R1 full"}, st_full, full);
    chk({req, " R7 empty"}, st_empty, exp_q.size() == 0);
    chk({req, " R3/R5 perr"}, st_perr, m_perr);
    chk({req, " R9 overrun"}, st_overrun, m_ovr);
    chk({req, " R11 irq_n"}, irq_n, !(full || m_perr || m_ovr));
  endtask

  // driver: one character beat, model updated from the requirements
  task automatic send(logic [7:0] d, logic p);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_perr = p;
    if (!cfg_t1 && p) begin
      if (m_armed) begin
        m_cnt++;
        if (m_cnt == int'(cfg_err_lim) + 1) begin m_perr = 1; m_armed = 0; end
      end
    end else begin
      if (exp_q.size() >= int'(cfg_depth) + 1) m_ovr = 1;
      else exp_q.push_back(d);
      if (p) m_perr = 1;
    end
    @(negedge clk);
    in_valid = 1'b0; in_perr = 1'b0;
  endtask

  // monitor: pop one character and compare against the scoreboard
  task automatic take(string req);
    logic [7:0] e;
    @(negedge clk);
    chk({req, " R7 out_valid"}, out_valid, 1'b1);
    e = exp_q.pop_front();
    chk({req, " R7 order"}, out_data, e);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic read_status();
    @(negedge clk);
    stat_rd = 1'b1; m_perr = 0; m_ovr = 0;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic reload();
    @(negedge clk);
    cfg_err_load = 1'b1; m_cnt = 0; m_armed = 1;
    @(negedge clk);
    cfg_err_load = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_status("reset");
    chk("R7 in_ready", in_ready, 1'b1);
    chk("R7 out_valid empty", out_valid, 1'b0);

    // depth 4, T=0, clean characters
    send(8'h11, 0); send(8'h22, 0); send(8'h33, 0);
    check_status("three of four");
    send(8'h44, 0);
    check_status("R1 depth four full");
    send(8'h55, 0);
    check_status("R9 overrun on full");
    take("R6 first read");
    check_status("R6 full released");
    read_status();
    check_status("R10 overrun cleared");
    take("drain"); take("drain"); take("drain");
    check_status("R7 empty again");

    // T=0 parity errors, limit 2
    cfg_err_lim = 3'd1; reload();
    send(8'hE1, 1);
    check_status("R2 dropped first error");
    send(8'hE2, 1);
    check_status("R3 limit reached");
    read_status();
    check_status("R10 perr cleared");
    send(8'hE3, 1); send(8'hE4, 1);
    check_status("R3 disarmed count inert");
    cfg_err_lim = 3'd0; reload();
    send(8'hE5, 1);
    check_status("R4 reloaded limit one");
    read_status();

    // T=1 parity policy
    cfg_t1 = 1'b1;
    send(8'h5A, 1);
    check_status("R5 stored with error");
    take("R5 byte kept");
    @(negedge clk);
    stat_rd = 1'b1; in_valid = 1'b1; in_data = 8'h6B; in_perr = 1'b1;
    exp_q.push_back(8'h6B); m_ovr = 0; m_perr = 1;
    @(negedge clk);
    stat_rd = 1'b0; in_valid = 1'b0; in_perr = 1'b0;
    check_status("R10 set wins over clear");
    take("R10 drain");
    read_status();
    cfg_t1 = 1'b0;

    // depth 1
    cfg_depth = 3'd0;
    send(8'h77, 0);
    check_status("R1 depth one full");
    take("R6 depth one");
    check_status("R6 depth one released");

    // depth 8
    cfg_depth = 3'd7;
    for (int i = 0; i < 7; i++) send(8'(8'h80 + i), 0);
    check_status("R1 seven of eight");
    send(8'h87, 0);
    check_status("R1 depth eight full");

    // sync mode on the head 0x80
    cfg_sync = 1'b1; card_io = 1'b1;
    @(negedge clk);
    chk("R8 sync io high", out_data, 8'h81);
    card_io = 1'b0;
    @(negedge clk);
    chk("R8 sync io low", out_data, 8'h80);
    cfg_sync = 1'b0;
    for (int i = 0; i < 8; i++) take("depth eight drain");
    check_status("R7 final empty");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule